// File: doc/BRIEF.md
# Slave-DMA Data Window

This block carries the data phase of a flash command when the host CPU moves the bytes itself instead of a bus-mastering engine. When the command sequencer reaches a data phase, it presents the byte count and the direction for one cycle. The block clamps the count to the window capacity and latches both values into host-readable registers. If the count is non-zero, it also raises a trigger interrupt. The host then streams bytes one at a time through a single window port. A small FIFO sits between that port and an abstract flash-side byte stream.

Each window transfer moves exactly one byte. An internal counter tracks progress against the latched size, and a done level tells the sequencer that the data phase has finished. The command as a whole still needs its own command-done interrupt from the sequencer before it counts as complete. This block only reports the end of the data movement.

The block never hangs the host on a bad access. A window access in the wrong direction, an access after the count is reached, or an access while no transfer is loaded completes at once and is otherwise ignored. Such an access raises an error interrupt. The two interrupt flags are write-1-to-clear.

The window and flash-side ports are valid/ready streams, and a byte moves on any cycle where both valid and ready are high. The block applies back-pressure only on a legal access:
- A window read is held off while the FIFO is empty.
- A window write is held off while the FIFO is full.
- The flash side is refused once the FIFO is full or the latched count of bytes has entered.

A source holding valid against a low ready must keep its data stable.

Top module: `sdma_window`

## Requirements
- R1: A start pulse latches the byte count, clamped to WINDOW_BYTES (default 64) when larger; the latched count reads back zero-extended at register offset 0x240.
- R2: The latched direction reads back at offset 0x244 in bit 8, where 0 means data flows from flash to host and 1 means host to flash; all other bits read 0.
- R3: A start with a non-zero count sets the trigger flag, visible on `irq_trigger` and at offset 0x248 bit 0.
- R4: A start with a count of zero does not set the trigger flag and raises `data_done` immediately.
- R5: The flags at offset 0x248 (bit 0 trigger, bit 1 error) are cleared by writing 1 to their bit; writing 0 leaves a bit unchanged; all flags are 0 after reset.
- R6: In flash-to-host mode, bytes accepted on the flash stream leave the window in arrival order. A legal window read is held with ready low while the FIFO is empty. The flash stream is refused while the FIFO is full and after the latched count of bytes has entered.
- R7: In host-to-flash mode, window bytes leave the flash stream in write order. A legal window write is held with ready low while the FIFO is full. The flash stream holds valid and data stable until it is taken.
- R8: `data_done` rises once the window has moved the latched count of bytes and, in host-to-flash mode, the FIFO has drained. It then stays high until the next start.
- R9: A window write in flash-to-host mode, or a window read in host-to-flash mode, completes at once, sets the error flag, and moves no data and no count.
- R10: A window access after the count is reached, or before any start, completes at once, sets the error flag, and is otherwise ignored.
- R11: After reset both interrupts and `data_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | One-cycle pulse from the sequencer entering a data phase |
| start_size | input | SIZE_W | Requested byte count |
| start_dir | input | 1 | 0 flash-to-host, 1 host-to-flash |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| win_wr_valid | input | 1 | Host offers a byte to the window |
| win_wr_data | input | 8 | Byte written by the host |
| win_wr_ready | output | 1 | Window write accepted this cycle |
| win_rd_valid | input | 1 | Host requests a byte from the window |
| win_rd_data | output | 8 | Byte returned to the host |
| win_rd_ready | output | 1 | Window read completes this cycle |
| fl_in_valid | input | 1 | Flash stream offers a byte |
| fl_in_data | input | 8 | Byte from flash |
| fl_in_ready | output | 1 | Block accepts the flash byte |
| fl_out_valid | output | 1 | Block offers a byte to flash |
| fl_out_data | output | 8 | Byte to flash |
| fl_out_ready | input | 1 | Flash stream takes the byte |
| irq_trigger | output | 1 | Trigger flag |
| irq_error | output | 1 | Error flag |
| data_done | output | 1 | Data phase finished |

## Verification
The hardest state to reach is the host-to-flash case where the host has written its last byte but the FIFO still holds data. Here the host count is complete, yet `data_done` must stay low, and a further window write must be rejected without slipping into the FIFO. The bench gets there by filling the FIFO with the flash side stalled, draining only part of it, and then writing the remaining bytes. It then probes `data_done`, makes an overrun write, and pulls the whole FIFO to prove the extra byte never entered. The full-FIFO and empty-FIFO stalls are reached the same way, by holding the opposite stream idle.

// File: rtl/sdmw_pkg.sv
package sdmw_pkg;
  typedef enum logic {
    DIR_FROM_FLASH = 1'b0,
    DIR_TO_FLASH   = 1'b1
  } sdmw_dir_e;

  localparam logic [11:0] OFS_SIZE  = 12'h240;
  localparam logic [11:0] OFS_INFO  = 12'h244;
  localparam logic [11:0] OFS_FLAGS = 12'h248;

  localparam int INFO_DIR_BIT  = 8;
  localparam int FLAG_TRIG_BIT = 0;
  localparam int FLAG_ERR_BIT  = 1;
endpackage

// File: rtl/sdmw_fifo.sv
module sdmw_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] pop_data,
  output logic         full,
  output logic         empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  assign full     = (count == CNT_W'(DEPTH));
  assign empty    = (count == '0);
  assign pop_data = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push && !full) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push && !full)  wr_ptr <= bump(wr_ptr);
      if (pop && !empty)  rd_ptr <= bump(rd_ptr);
      case ({push && !full, pop && !empty})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/sdmw_ctrl.sv
module sdmw_ctrl
  import sdmw_pkg::*;
#(
  parameter int SIZE_W       = 16,
  parameter int WINDOW_BYTES = 64,
  parameter int CNT_W        = $clog2(WINDOW_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  input  logic [SIZE_W-1:0] start_size,
  input  logic              start_dir,
  input  logic              win_wr_valid,
  input  logic              win_rd_valid,
  input  logic              fl_in_valid,
  input  logic              fl_out_ready,
  input  logic              fifo_full,
  input  logic              fifo_empty,
  output logic [CNT_W-1:0]  size_q,
  output sdmw_dir_e         dir_q,
  output logic              win_wr_ready,
  output logic              win_rd_ready,
  output logic              rd_legal,
  output logic              host_push,
  output logic              host_pop,
  output logic              fl_in_ready,
  output logic              fl_out_valid,
  output logic              fl_pop,
  output logic              fl_push,
  output logic              set_trig,
  output logic              set_err,
  output logic              data_done
);
  logic             loaded;
  logic [CNT_W-1:0] host_cnt, fl_cnt, lim;
  logic             room, wr_legal;

  always_comb begin
    if (start_size > SIZE_W'(WINDOW_BYTES)) lim = CNT_W'(WINDOW_BYTES);
    else                                    lim = start_size[CNT_W-1:0];
  end

  assign room     = loaded && (host_cnt != size_q);
  assign wr_legal = room && (dir_q == DIR_TO_FLASH);
  assign rd_legal = room && (dir_q == DIR_FROM_FLASH);

  assign win_wr_ready = wr_legal ? !fifo_full  : 1'b1;
  assign win_rd_ready = rd_legal ? !fifo_empty : 1'b1;
  assign host_push    = win_wr_valid && wr_legal && !fifo_full;
  assign host_pop     = win_rd_valid && rd_legal && !fifo_empty;

  assign fl_in_ready  = loaded && (dir_q == DIR_FROM_FLASH) &&
                        (fl_cnt != size_q) && !fifo_full;
  assign fl_push      = fl_in_valid && fl_in_ready;
  assign fl_out_valid = loaded && (dir_q == DIR_TO_FLASH) && !fifo_empty;
  assign fl_pop       = fl_out_valid && fl_out_ready;

  assign set_trig  = start_valid && (lim != '0);
  assign set_err   = (win_wr_valid && !wr_legal) || (win_rd_valid && !rd_legal);
  assign data_done = loaded && (host_cnt == size_q) &&
                     ((dir_q == DIR_FROM_FLASH) || fifo_empty);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded   <= 1'b0;
      size_q   <= '0;
      dir_q    <= DIR_FROM_FLASH;
      host_cnt <= '0;
      fl_cnt   <= '0;
    end else if (start_valid) begin
      loaded   <= 1'b1;
      size_q   <= lim;
      dir_q    <= sdmw_dir_e'(start_dir);
      host_cnt <= '0;
      fl_cnt   <= '0;
    end else begin
      if (host_push || host_pop) host_cnt <= host_cnt + 1'b1;
      if (fl_push)               fl_cnt   <= fl_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sdmw_regs.sv
module sdmw_regs
  import sdmw_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [11:0]      reg_addr,
  input  logic [31:0]      reg_wdata,
  input  logic             set_trig,
  input  logic             set_err,
  input  logic [CNT_W-1:0] size_q,
  input  sdmw_dir_e        dir_q,
  output logic [31:0]      reg_rdata,
  output logic             irq_trigger,
  output logic             irq_error
);
  logic clr_trig, clr_err;
  logic unused_wdata;

  assign unused_wdata = ^reg_wdata[31:2];
  assign clr_trig = reg_wr && (reg_addr == OFS_FLAGS) && reg_wdata[FLAG_TRIG_BIT];
  assign clr_err  = reg_wr && (reg_addr == OFS_FLAGS) && reg_wdata[FLAG_ERR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_trigger <= 1'b0;
      irq_error   <= 1'b0;
    end else begin
      if (set_trig)      irq_trigger <= 1'b1;
      else if (clr_trig) irq_trigger <= 1'b0;
      if (set_err)       irq_error   <= 1'b1;
      else if (clr_err)  irq_error   <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_SIZE:  reg_rdata[CNT_W-1:0]     = size_q;
      OFS_INFO:  reg_rdata[INFO_DIR_BIT]  = (dir_q == DIR_TO_FLASH);
      OFS_FLAGS: begin
        reg_rdata[FLAG_TRIG_BIT] = irq_trigger;
        reg_rdata[FLAG_ERR_BIT]  = irq_error;
      end
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sdma_window.sv
module sdma_window
  import sdmw_pkg::*;
#(
  parameter int SIZE_W       = 16,
  parameter int WINDOW_BYTES = 64,
  parameter int FIFO_DEPTH   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  input  logic [SIZE_W-1:0] start_size,
  input  logic              start_dir,
  input  logic              reg_wr,
  input  logic [11:0]       reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              win_wr_valid,
  input  logic [7:0]        win_wr_data,
  output logic              win_wr_ready,
  input  logic              win_rd_valid,
  output logic [7:0]        win_rd_data,
  output logic              win_rd_ready,
  input  logic              fl_in_valid,
  input  logic [7:0]        fl_in_data,
  output logic              fl_in_ready,
  output logic              fl_out_valid,
  output logic [7:0]        fl_out_data,
  input  logic              fl_out_ready,
  output logic              irq_trigger,
  output logic              irq_error,
  output logic              data_done
);
  localparam int CNT_W = $clog2(WINDOW_BYTES + 1);

  logic [CNT_W-1:0] size_q;
  sdmw_dir_e        dir_q;
  logic             rd_legal, host_push, host_pop, fl_push, fl_pop;
  logic             set_trig, set_err, fifo_full, fifo_empty;
  logic [7:0]       fifo_in, fifo_out;

  sdmw_ctrl #(.SIZE_W(SIZE_W), .WINDOW_BYTES(WINDOW_BYTES), .CNT_W(CNT_W)) u_ctrl (
    .clk, .rst_n, .start_valid, .start_size, .start_dir,
    .win_wr_valid, .win_rd_valid, .fl_in_valid, .fl_out_ready,
    .fifo_full, .fifo_empty, .size_q, .dir_q,
    .win_wr_ready, .win_rd_ready, .rd_legal, .host_push, .host_pop,
    .fl_in_ready, .fl_out_valid, .fl_pop, .fl_push,
    .set_trig, .set_err, .data_done
  );

  assign fifo_in = (dir_q == DIR_TO_FLASH) ? win_wr_data : fl_in_data;

  sdmw_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk, .rst_n,
    .flush     (start_valid),
    .push      (host_push || fl_push),
    .push_data (fifo_in),
    .pop       (host_pop || fl_pop),
    .pop_data  (fifo_out),
    .full      (fifo_full),
    .empty     (fifo_empty)
  );

  assign win_rd_data = rd_legal ? fifo_out : 8'h00;
  assign fl_out_data = fifo_out;

  sdmw_regs #(.CNT_W(CNT_W)) u_regs (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata,
    .set_trig, .set_err, .size_q, .dir_q,
    .reg_rdata, .irq_trigger, .irq_error
  );
endmodule

// File: rtl/sdma_window_checker.sv
module sdma_window_checker #(
  parameter int SIZE_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_valid,
  input logic [SIZE_W-1:0] start_size,
  input logic              win_wr_valid,
  input logic              win_rd_valid,
  input logic              fl_out_valid,
  input logic [7:0]        fl_out_data,
  input logic              fl_out_ready,
  input logic              irq_trigger,
  input logic              irq_error,
  input logic              data_done
);
  p_trig_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_trigger) |-> $past(start_valid));

  p_zero_no_trig_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && start_size == '0 && !irq_trigger) |=> !irq_trigger);

  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_out_valid && !fl_out_ready && !start_valid) |=>
      (fl_out_valid && $stable(fl_out_data)));

  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_done && !start_valid) |=> data_done);

  p_err_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_error) |-> $past(win_wr_valid || win_rd_valid));
endmodule

bind sdma_window sdma_window_checker #(.SIZE_W(SIZE_W)) u_chk (
  .clk, .rst_n, .start_valid, .start_size, .win_wr_valid, .win_rd_valid,
  .fl_out_valid, .fl_out_data, .fl_out_ready, .irq_trigger, .irq_error, .data_done
);

// File: tb/sdma_window_bench.sv
module sdma_window_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_valid = 1'b0;
  logic [15:0] start_size = '0;
  logic        start_dir = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        win_wr_valid = 1'b0;
  logic [7:0]  win_wr_data = '0;
  logic        win_wr_ready;
  logic        win_rd_valid = 1'b0;
  logic [7:0]  win_rd_data;
  logic        win_rd_ready;
  logic        fl_in_valid = 1'b0;
  logic [7:0]  fl_in_data = '0;
  logic        fl_in_ready;
  logic        fl_out_valid;
  logic [7:0]  fl_out_data;
  logic        fl_out_ready = 1'b0;
  logic        irq_trigger, irq_error, data_done;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  sdma_window u_sdma_window (
    .clk, .rst_n, .start_valid, .start_size, .start_dir,
    .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .win_wr_valid, .win_wr_data, .win_wr_ready,
    .win_rd_valid, .win_rd_data, .win_rd_ready,
    .fl_in_valid, .fl_in_data, .fl_in_ready,
    .fl_out_valid, .fl_out_data, .fl_out_ready,
    .irq_trigger, .irq_error, .data_done
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic reg_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic start(input logic [15:0] n, input logic dir);
    @(negedge clk); start_valid = 1'b1; start_size = n; start_dir = dir;
    @(negedge clk); start_valid = 1'b0;
  endtask

  task automatic flash_push(input logic [7:0] d, output logic ok);
    @(negedge clk); fl_in_valid = 1'b1; fl_in_data = d; #1; ok = fl_in_ready;
    @(negedge clk); fl_in_valid = 1'b0;
  endtask

  task automatic flash_pull(output logic [7:0] d, output logic ok);
    @(negedge clk); fl_out_ready = 1'b1; #1; ok = fl_out_valid; d = fl_out_data;
    @(negedge clk); fl_out_ready = 1'b0;
  endtask

  task automatic win_read(output logic [7:0] d, output logic ok);
    @(negedge clk); win_rd_valid = 1'b1; #1; ok = win_rd_ready; d = win_rd_data;
    @(negedge clk); win_rd_valid = 1'b0;
  endtask

  task automatic win_write(input logic [7:0] d, output logic ok);
    @(negedge clk); win_wr_valid = 1'b1; win_wr_data = d; #1; ok = win_wr_ready;
    @(negedge clk); win_wr_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] r;
    #1;
    chk("R11", "irq_trigger after reset", 32'(irq_trigger), 0);
    chk("R11", "irq_error after reset", 32'(irq_error), 0);
    chk("R11", "data_done after reset", 32'(data_done), 0);
    reg_read(12'h248, r);
    chk("R5", "flags after reset", r, 0);
  endtask

  task automatic t_read_xfer();
    logic [31:0] r; logic [7:0] d; logic ok;
    start(16'd5, 1'b0);
    chk("R3", "trigger after start", 32'(irq_trigger), 1);
    reg_read(12'h240, r); chk("R1", "size reg", r, 5);
    reg_read(12'h244, r); chk("R2", "info reg read dir", r, 0);
    reg_read(12'h248, r); chk("R3", "flag bit0", r, 1);
    win_read(d, ok);
    chk("R6", "read stalls on empty", 32'(ok), 0);
    chk("R6", "stall is no error", 32'(irq_error), 0);
    for (int i = 0; i < 4; i++) begin
      flash_push(8'hA0 + 8'(i), ok);
      chk("R6", "flash push accepted", 32'(ok), 1);
    end
    flash_push(8'hEE, ok);
    chk("R6", "flash refused when full", 32'(ok), 0);
    for (int i = 0; i < 4; i++) begin
      win_read(d, ok);
      chk("R6", "window read ready", 32'(ok), 1);
      chk("R6", "window read order", 32'(d), 32'(8'hA0 + 8'(i)));
    end
    flash_push(8'hA4, ok);
    chk("R6", "last flash byte", 32'(ok), 1);
    flash_push(8'hEF, ok);
    chk("R6", "flash refused past count", 32'(ok), 0);
    chk("R8", "not done before last read", 32'(data_done), 0);
    win_read(d, ok);
    chk("R6", "last byte value", 32'(d), 32'hA4);
    #1; chk("R8", "done after count", 32'(data_done), 1);
    win_read(d, ok);
    chk("R10", "overrun read completes", 32'(ok), 1);
    #1; chk("R10", "overrun sets error", 32'(irq_error), 1);
    chk("R8", "done holds", 32'(data_done), 1);
    reg_write(12'h248, 32'h0);
    reg_read(12'h248, r); chk("R5", "write 0 keeps flags", r, 3);
    reg_write(12'h248, 32'h3);
    reg_read(12'h248, r); chk("R5", "write 1 clears flags", r, 0);
  endtask

  task automatic t_write_xfer();
    logic [31:0] r; logic [7:0] d; logic ok;
    start(16'd6, 1'b1);
    reg_read(12'h244, r); chk("R2", "info reg write dir", r, 32'h100);
    win_read(d, ok);
    chk("R9", "wrong-dir read completes", 32'(ok), 1);
    #1; chk("R9", "wrong-dir sets error", 32'(irq_error), 1);
    reg_write(12'h248, 32'h2);
    reg_read(12'h248, r); chk("R5", "clear error only", r, 1);
    for (int i = 0; i < 4; i++) begin
      win_write(8'hB0 + 8'(i), ok);
      chk("R7", "window write accepted", 32'(ok), 1);
    end
    win_write(8'hCC, ok);
    chk("R7", "write stalls when full", 32'(ok), 0);
    for (int i = 0; i < 2; i++) begin
      flash_pull(d, ok);
      chk("R7", "flash out valid", 32'(ok), 1);
      chk("R7", "flash out order", 32'(d), 32'(8'hB0 + 8'(i)));
    end
    win_write(8'hB4, ok); chk("R7", "write B4", 32'(ok), 1);
    win_write(8'hB5, ok); chk("R7", "write B5", 32'(ok), 1);
    #1; chk("R8", "not done until drained", 32'(data_done), 0);
    win_write(8'hDD, ok);
    chk("R10", "overrun write completes", 32'(ok), 1);
    #1; chk("R10", "overrun write error", 32'(irq_error), 1);
    for (int i = 2; i < 6; i++) begin
      flash_pull(d, ok);
      chk("R7", "drain valid", 32'(ok), 1);
      chk("R7", "drain order", 32'(d), 32'(8'hB0 + 8'(i)));
    end
    flash_pull(d, ok);
    chk("R10", "overrun byte not stored", 32'(ok), 0);
    #1; chk("R8", "done after drain", 32'(data_done), 1);
    reg_write(12'h248, 32'h3);
  endtask

  task automatic t_clamp();
    logic [31:0] r;
    start(16'd200, 1'b0);
    reg_read(12'h240, r); chk("R1", "clamped size", r, 64);
    start(16'd64, 1'b1);
    reg_read(12'h240, r); chk("R1", "size at limit", r, 64);
    reg_write(12'h248, 32'h3);
  endtask

  task automatic t_zero();
    logic [31:0] r;
    start(16'd0, 1'b0);
    #1;
    chk("R4", "no trigger for zero", 32'(irq_trigger), 0);
    chk("R4", "zero done at once", 32'(data_done), 1);
    reg_read(12'h240, r); chk("R1", "zero size reg", r, 0);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_read_xfer();
    t_write_xfer();
    t_clamp();
    t_zero();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule